// File: doc/BRIEF.md
# Rotating Daisy-Chain Bus Grant Node

This block is the arbitration logic that sits in one slot of a backplane where the bus grant is handed from slot to slot along a daisy chain. Every slot contributes to one shared request line, and that line is the OR of all slot requests. The same line also acts as the grant entering the first slot. The local bus master raises `wantBus` when it needs the bus. It is told it owns the bus through `ownerFlag`, and it ends its tenure with a one-cycle `doneStb`.

The node does not use fixed slot priority. A master that asks for the bus while the grant is already travelling down the chain does not join that round. It holds back until the round has drained, which it detects as the global request line going low. As a result, ownership visits every requesting slot once per round, in chain order, much like a ring. A slot that has just released the bus cannot take it again until all the other requests of the current round have been served.

Every output comes from a register clocked on `clk`, so each slot adds one cycle of grant latency. Reset is synchronous and active low.

Top module: `dcgrant_node`

## Requirements
- R1: When `rstN` is sampled low at a rising edge, the node returns to pass-through with `reqOut`, `grantOut` and `ownerFlag` all 0, even if it owned the bus.
- R2: A node that does not want the bus drives `grantOut`, one cycle later, to the value `grantIn AND reqIn` it sampled.
- R3: Whenever `reqIn` is sampled low, `grantOut` is 0 in the next cycle, whatever `grantIn` is.
- R4: A passive node that samples `wantBus` high, and does not see `reqIn` and `grantIn` both high, drives `reqOut` to 1 and `grantOut` to 0 in the next cycle.
- R5: A node that samples `wantBus` high while `reqIn` and `grantIn` are both high does not raise `reqOut`. It keeps passing the grant and waits. Its request is raised one cycle after the first edge at which `reqIn` is sampled low (a grant seen with `reqIn` low counts as negated).
- R6: A requesting node that samples `grantIn` and `reqIn` high with `wantBus` still high shows `ownerFlag` = 1 in the next cycle. At that point `reqOut` stays 1 and `grantOut` stays 0.
- R7: While `ownerFlag` is 1, `grantOut` is 0 and `reqOut` is 1. Ownership ends only on `doneStb`: dropping `wantBus` has no effect while owning, and `doneStb` has no effect when not owning.
- R8: `doneStb` sampled while owning gives `ownerFlag` = 0 and `reqOut` = 0 in the next cycle, and `grantOut` then passes `grantIn AND reqIn`. If the node still wants the bus while the round continues, it defers as in R5.
- R9: A requesting node that samples `wantBus` low before it is granted drops `reqOut` in the next cycle and resumes pass-through.
- R10: In a chain of four nodes that all request continuously, with the first grant input tied to the OR of the requests, ownership moves through the slots in chain order 0,1,2,3 in every round, and no two nodes own the bus at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wantBus | input | 1 | Local master wants the bus |
| reqIn | input | 1 | Global request line (OR of all slot requests) |
| grantIn | input | 1 | Grant from the previous slot |
| doneStb | input | 1 | One-cycle strobe from the local master ending its tenure |
| reqOut | output | 1 | This slot's contribution to the global request |
| grantOut | output | 1 | Grant to the next slot |
| ownerFlag | output | 1 | Local master owns the bus |

## Verification
The assertions only refer to the ports. They assume that `reqIn` behaves like a real wired OR, so it is high whenever this node's own `reqOut` is high. They also assume that `doneStb` is a short pulse from the local master. In the single-node vector walk, `reqIn` is always driven high in any step where the node is expected to be requesting or owning. The one exception is a deliberately stale grant with `reqIn` low, which tests the drain rule. In the four-node chain, `reqIn` is computed from the OR of the real `reqOut` outputs, and `doneStb` is raised only during a node's own tenure.

// File: rtl/dcgrant_pkg.sv
package dcgrant_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,  // pass-through, not interested
    ST_DEFER   = 3'd1,  // round in progress, wait for drain
    ST_REQUEST = 3'd2,  // request raised, waiting for grant
    ST_OWN     = 3'd3,  // tenure
    ST_RELEASE = 3'd4   // one cycle hand-back
  } nodeState_e;

  typedef struct packed {
    logic reqOn;      // request-out value for next cycle
    logic ownOn;      // owner flag value for next cycle
    logic passGrant;  // copy gated grant to next slot
  } nodeStrobes_t;

endpackage

// File: rtl/dcgrant_ctrl.sv
module dcgrant_ctrl
  import dcgrant_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wantBus,
  input  logic         reqIn,
  input  logic         grantIn,
  input  logic         doneStb,
  output nodeStrobes_t strobes
);

  nodeState_e stateQ, stateNext;
  logic       roundBusy;

  // A grant only counts while the request line is up.
  assign roundBusy = reqIn & grantIn;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (wantBus) stateNext = roundBusy ? ST_DEFER : ST_REQUEST;
      end
      ST_DEFER: begin
        if (!wantBus)    stateNext = ST_IDLE;
        else if (!reqIn) stateNext = ST_REQUEST;
      end
      ST_REQUEST: begin
        if (!wantBus)       stateNext = ST_IDLE;
        else if (roundBusy) stateNext = ST_OWN;
      end
      ST_OWN: begin
        if (doneStb) stateNext = ST_RELEASE;
      end
      ST_RELEASE: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  // Strobes describe the outputs of the state being entered.
  always_comb begin
    strobes.reqOn     = (stateNext == ST_REQUEST) || (stateNext == ST_OWN);
    strobes.ownOn     = (stateNext == ST_OWN);
    strobes.passGrant = (stateNext == ST_IDLE) || (stateNext == ST_DEFER) ||
                        (stateNext == ST_RELEASE);
  end

endmodule

// File: rtl/dcgrant_dp.sv
module dcgrant_dp
  import dcgrant_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  nodeStrobes_t strobes,
  input  logic         reqIn,
  input  logic         grantIn,
  output logic         reqOut,
  output logic         grantOut,
  output logic         ownerFlag
);

  logic reqQ, grantQ, ownQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ   <= 1'b0;
      grantQ <= 1'b0;
      ownQ   <= 1'b0;
    end else begin
      reqQ   <= strobes.reqOn;
      ownQ   <= strobes.ownOn;
      grantQ <= strobes.passGrant & grantIn & reqIn;
    end
  end

  assign reqOut    = reqQ;
  assign grantOut  = grantQ;
  assign ownerFlag = ownQ;

endmodule

// File: rtl/dcgrant_node.sv
module dcgrant_node
  import dcgrant_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wantBus,
  input  logic reqIn,
  input  logic grantIn,
  input  logic doneStb,
  output logic reqOut,
  output logic grantOut,
  output logic ownerFlag
);

  nodeStrobes_t strobes;

  dcgrant_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wantBus (wantBus),
    .reqIn   (reqIn),
    .grantIn (grantIn),
    .doneStb (doneStb),
    .strobes (strobes)
  );

  dcgrant_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqIn     (reqIn),
    .grantIn   (grantIn),
    .reqOut    (reqOut),
    .grantOut  (grantOut),
    .ownerFlag (ownerFlag)
  );

endmodule

// File: rtl/dcgrant_node_chk.sv
module dcgrant_node_chk (
  input logic clk,
  input logic rstN,
  input logic wantBus,
  input logic reqIn,
  input logic grantIn,
  input logic doneStb,
  input logic reqOut,
  input logic grantOut,
  input logic ownerFlag
);

  // R3: no request on the line means no grant one cycle later
  a_r3_idle_line: assert property (@(posedge clk) disable iff (!rstN)
    !reqIn |=> !grantOut);

  // R5: a running round is never joined
  a_r5_no_join: assert property (@(posedge clk) disable iff (!rstN)
    (!reqOut && reqIn && grantIn) |=> !reqOut);

  // R6: a requester that sees the grant takes ownership
  a_r6_take: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut && !ownerFlag && wantBus && reqIn && grantIn) |=> ownerFlag);

  // R7: the owner blocks the chain and keeps requesting
  a_r7_owner_blocks: assert property (@(posedge clk) disable iff (!rstN)
    ownerFlag |-> (!grantOut && reqOut));

  // R7: ownership only ends on the done strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ownerFlag && !doneStb) |=> ownerFlag);

  // R8: done ends the tenure and drops the request
  a_r8_release: assert property (@(posedge clk) disable iff (!rstN)
    (ownerFlag && doneStb) |=> (!ownerFlag && !reqOut));

  // R9: withdrawing before the grant drops the request
  a_r9_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    (reqOut && !ownerFlag && !wantBus) |=> (!reqOut && !ownerFlag));

endmodule

bind dcgrant_node dcgrant_node_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .wantBus   (wantBus),
  .reqIn     (reqIn),
  .grantIn   (grantIn),
  .doneStb   (doneStb),
  .reqOut    (reqOut),
  .grantOut  (grantOut),
  .ownerFlag (ownerFlag)
);

// File: tb/dcgrant_node_tb_top.sv
`timescale 1ns/1ps
module dcgrant_node_tb_top;

  localparam int NUM_VEC    = 21;
  localparam int NODES      = 4;
  localparam int HOLD       = 3;
  localparam int TENURES    = 12;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // single node under vector test
  logic rstN = 1'b0;
  logic wantBus = 1'b0, reqIn = 1'b0, grantIn = 1'b0, doneStb = 1'b0;
  logic reqOut, grantOut, ownerFlag;

  dcgrant_node dut_i (
    .clk(clk), .rstN(rstN), .wantBus(wantBus), .reqIn(reqIn),
    .grantIn(grantIn), .doneStb(doneStb), .reqOut(reqOut),
    .grantOut(grantOut), .ownerFlag(ownerFlag)
  );

  // four-node chain for the rotation test
  logic             chainRstN = 1'b0;
  logic [NODES-1:0] chainWant = '0;
  logic [NODES-1:0] chainDone = '0;
  logic [NODES-1:0] chainReq, chainGrantOut, chainOwn;
  logic [NODES-1:0] chainGrantIn;
  logic             chainLine;

  assign chainLine = |chainReq;
  assign chainGrantIn[0] = chainLine;
  for (genvar k = 1; k < NODES; k++) begin : g_link
    assign chainGrantIn[k] = chainGrantOut[k-1];
  end

  for (genvar k = 0; k < NODES; k++) begin : g_chain
    dcgrant_node node_i (
      .clk(clk), .rstN(chainRstN), .wantBus(chainWant[k]), .reqIn(chainLine),
      .grantIn(chainGrantIn[k]), .doneStb(chainDone[k]), .reqOut(chainReq[k]),
      .grantOut(chainGrantOut[k]), .ownerFlag(chainOwn[k])
    );
  end

  // {want, reqIn, grantIn, done, expReq, expGrant, expOwn}
  localparam logic [6:0] VEC [NUM_VEC] = '{
    7'b0000_000, // 0  R2 idle
    7'b0110_010, // 1  R2 pass grant
    7'b0010_000, // 2  R3 line low blocks grant
    7'b0100_000, // 3  R2 no grant
    7'b1110_010, // 4  R5 defer, keep passing
    7'b1100_000, // 5  R5 still deferring
    7'b1110_010, // 6  R5 still deferring
    7'b1010_100, // 7  R5 line drained -> request
    7'b1100_100, // 8  R4 waiting
    7'b1111_101, // 9  R6 grant taken, done ignored
    7'b0110_101, // 10 R7 want drop ignored
    7'b1111_010, // 11 R8 release passes grant
    7'b1110_010, // 12 R8 back to pass-through
    7'b1110_010, // 13 R8 no rejoin in same round
    7'b1000_100, // 14 R5 drained -> request
    7'b0100_000, // 15 R9 withdraw
    7'b1100_100, // 16 R4 request with line high
    7'b1110_101, // 17 R6 own
    7'b1101_000, // 18 R8 release, grant low
    7'b0110_010, // 19 R2 pass-through again
    7'b0001_000  // 20 R7 done outside tenure ignored
  };

  string vecTag [NUM_VEC] = '{
    "R2", "R2", "R3", "R2", "R5", "R5", "R5", "R5", "R4", "R6", "R7",
    "R8", "R8", "R8", "R5", "R9", "R4", "R6", "R8", "R2", "R7"
  };

  task automatic check(input string tag, input string what,
                       input logic [2:0] got, input logic [2:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: got req/grant/own=%b expected %b", tag, what, got, exp);
    end
  endtask

  // chain bookkeeping
  int               tenureCnt = 0;
  int               expOwner = 0;
  logic [NODES-1:0] prevOwn = '0;
  int               holdCnt [NODES];

  initial begin
    // reset state, R1
    repeat (3) @(negedge clk);
    check("R1", "reset state", {reqOut, grantOut, ownerFlag}, 3'b000);
    rstN = 1'b1;

    // vector walk
    for (int i = 0; i < NUM_VEC; i++) begin
      {wantBus, reqIn, grantIn, doneStb} = VEC[i][6:3];
      @(negedge clk);
      check(vecTag[i], $sformatf("vector %0d", i),
            {reqOut, grantOut, ownerFlag}, VEC[i][2:0]);
    end

    // R1: reset in the middle of a tenure
    {wantBus, reqIn, grantIn, doneStb} = 4'b1000;
    @(negedge clk);
    {wantBus, reqIn, grantIn, doneStb} = 4'b1110;
    @(negedge clk);
    check("R6", "owned before reset", {reqOut, grantOut, ownerFlag}, 3'b101);
    rstN = 1'b0;
    @(negedge clk);
    check("R1", "reset during tenure", {reqOut, grantOut, ownerFlag}, 3'b000);
    rstN = 1'b1;
    {wantBus, reqIn, grantIn, doneStb} = 4'b0000;
    @(negedge clk);

    // R10: four chained nodes all requesting
    for (int k = 0; k < NODES; k++) holdCnt[k] = 0;
    repeat (2) @(negedge clk);
    chainRstN = 1'b1;
    chainWant = '1;
    for (int cyc = 0; cyc < 400 && tenureCnt < TENURES; cyc++) begin
      @(negedge clk);
      chainDone = '0;
      if ($countones(chainOwn) > 1) begin
        testsRun++;
        testsFailed++;
        $display("FAIL R10 two owners: got %b expected at most one bit", chainOwn);
      end
      for (int k = 0; k < NODES; k++) begin
        if (chainOwn[k] && !prevOwn[k]) begin
          testsRun++;
          if (k != expOwner) begin
            testsFailed++;
            $display("FAIL R10 tenure %0d: got node %0d expected node %0d",
                     tenureCnt, k, expOwner);
          end
          expOwner = (expOwner + 1) % NODES;
          tenureCnt++;
          holdCnt[k] = 0;
        end
        if (chainOwn[k]) begin
          holdCnt[k]++;
          if (holdCnt[k] == HOLD) chainDone[k] = 1'b1;
        end
      end
      prevOwn = chainOwn;
    end
    check("R10", "tenure count", 3'(tenureCnt == TENURES), 3'b001);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule